// File: doc/BRIEF.md
# Multithreaded Delay-Slot Fetch Sequencer

The block hands out instruction fetch addresses for several hardware threads. For each thread it keeps a window of three addresses: the address to fetch now, the one after it, and the one after that. It also keeps a per-thread fetch sequence number. Each granted fetch request returns the current address and the sequence number one cycle later, and the window moves forward by one instruction (4 bytes).

Branch resolution updates come in on a single port. A taken branch or a not-taken branch does not redirect fetch at once. The block stores the new target and a pending delay-slot count, so the delay-slot instruction is fetched first and the redirect takes effect on the fetch that follows. A taken branch and an annulling not-taken branch each issue a squash request on the kill outputs. A return that is not predicted taken sends a hold toward the reporting stage and stops fetch for its thread. Squash redirects from the pipeline arrive on several ports in the same cycle. For each thread only the oldest boundary is accepted. An accepted squash either reloads the window, or it queues the redirect behind a delay slot that has not yet been fetched. It restarts a stopped thread and raises a release bit toward the stage that was held.

Each thread runs a three-state machine: TH_OFF (not fetching), TH_RUN (fetching), TH_WAIT_RET (waiting for a return address). Its transitions are:
- TH_OFF to TH_RUN on an activate or an accepted squash.
- TH_RUN to TH_WAIT_RET on a not-taken return update.
- TH_WAIT_RET to TH_RUN on an activate or an accepted squash.
- Any state to TH_OFF on a deactivate.

Top module: `fetch_sequencer`

## Requirements
- R1: After reset every thread is in TH_OFF. rsp_valid, kill_valid, hold_valid and release_mask are all zero, and every per-thread sequence number is 0.
- R2: An activate loads a thread's window with pc, pc+4 and pc+8 and puts the thread in TH_RUN. Each granted fetch returns the current address and the thread's sequence number on rsp_addr and rsp_seq one cycle later. The window then advances by 4 bytes and the sequence number by 1. Each thread's state is independent of the others.
- R3: A fetch request for a thread that is not in TH_RUN gives rsp_stall=1 and rsp_valid=0 one cycle later. It does not consume a sequence number.
- R4: A br_kind=0 (taken) update for sequence s raises kill_valid one cycle later, with kill_seq=s+1 and kill_tid set to the thread. The next fetch returns the sequential delay-slot address. The fetch after that returns br_target, and fetch then continues from br_target+4.
- R5: A br_kind=2 (annulling, not taken) update for sequence s raises kill_valid with kill_seq=s. It queues no redirect, so the next fetch stays sequential.
- R6: A br_kind=1 (plain not-taken) update raises no kill. It queues br_pc+8 behind one delay slot.
- R7: A br_kind=3 (return, not taken) update moves the thread to TH_WAIT_RET. One cycle later it raises hold_valid with hold_tid and with hold_stage=br_stage. Later fetches for that thread stall.
- R8: For an accepted squash whose boundary differs from the thread's next sequence number, the window is reloaded from the redirect and any pending redirect is dropped. The redirect is sq_target when sq_ctrl=1 and sq_pc+4 otherwise.
- R9: When an accepted squash's boundary equals the thread's next sequence number, the delay slot has not been fetched yet. The next fetch then stays sequential, and the fetch after it returns the redirect.
- R10: An accepted squash puts its thread in TH_RUN. If the thread was not in TH_RUN, the thread's bit of release_mask rises one cycle later, and release_stage holds the stage recorded by the last return hold of that thread.
- R11: Among squash ports valid in the same cycle for one thread, only the one with the smallest boundary takes effect. On equal boundaries the lowest-numbered port wins.
- R12: A deactivate puts the thread in TH_OFF and drops its pending redirect. A later activate restarts it with no redirect left over.
- R13: Within one thread, deactivate, activate and squash in the same cycle override a branch update and a fetch. A fetch that collides with any update to its own thread stalls, while a fetch to another thread is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate a thread |
| act_tid | input | TW | Thread to activate |
| act_pc | input | AW | Start address for the activated thread |
| deact_valid | input | 1 | Deactivate a thread |
| deact_tid | input | TW | Thread to deactivate |
| fetch_req | input | 1 | Fetch address request |
| fetch_tid | input | TW | Thread for the fetch request |
| rsp_valid | output | 1 | Fetch granted; address and sequence are valid |
| rsp_stall | output | 1 | Fetch refused for this request |
| rsp_addr | output | AW | Granted fetch address |
| rsp_seq | output | SW | Sequence number of the granted fetch |
| br_valid | input | 1 | Branch resolution update |
| br_tid | input | TW | Thread of the branch |
| br_kind | input | 2 | 0 taken, 1 not taken, 2 annulling not taken, 3 return not taken |
| br_seq | input | SW | Sequence number of the branch |
| br_pc | input | AW | Address of the branch |
| br_target | input | AW | Predicted target of a taken branch |
| br_stage | input | STW | Pipeline stage reporting the update |
| kill_valid | output | 1 | Squash request toward the pipeline |
| kill_tid | output | TW | Thread to squash |
| kill_seq | output | SW | Squash instructions younger than this sequence |
| hold_valid | output | 1 | Hold request toward a stage |
| hold_tid | output | TW | Thread being held |
| hold_stage | output | STW | Stage that must hold |
| sq_valid | input | SQP | Squash redirect valid, one per port |
| sq_tid | input | SQP x TW | Thread of each squash |
| sq_bound | input | SQP x SW | Boundary sequence of each squash |
| sq_ctrl | input | SQP | Squashing instruction is a control instruction |
| sq_pc | input | SQP x AW | Address of the squashing instruction |
| sq_target | input | SQP x AW | Redirect target for control squashes |
| release_mask | output | NT | Per-thread release pulse toward the held stage |
| release_stage | output | NT x STW | Stage recorded for each thread's hold |

## Verification
The hardest case to reach is a squash that lands while its delay slot is still unfetched. This happens only when the boundary equals the thread's next sequence number. The stimulus keeps an exact count of granted fetches per thread, and it aims a squash boundary at that count and at values one below it. Contested squashes are built by driving two ports for one thread in one cycle: older on port 1, equal boundaries, and older on port 0. Each case is then read back by fetching. A return hold is set up first, so that a later squash shows the release pulse carrying the recorded stage.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [1:0] {
        BR_TAKEN     = 2'd0,
        BR_NOT_TAKEN = 2'd1,
        BR_ANNUL_NT  = 2'd2,
        BR_RETURN_NT = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        TH_OFF      = 2'd0,
        TH_RUN      = 2'd1,
        TH_WAIT_RET = 2'd2
    } th_state_e;

    localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/fs_squash_pick.sv
module fs_squash_pick #(
    parameter int NT  = 2,
    parameter int SQP = 2,
    parameter int TW  = 1,
    parameter int SW  = 16,
    parameter int AW  = 32
) (
    input  logic [SQP-1:0]         sq_valid,
    input  logic [SQP-1:0][TW-1:0] sq_tid,
    input  logic [SQP-1:0][SW-1:0] sq_bound,
    input  logic [SQP-1:0]         sq_ctrl,
    input  logic [SQP-1:0][AW-1:0] sq_pc,
    input  logic [SQP-1:0][AW-1:0] sq_target,
    output logic [NT-1:0]          take_o,
    output logic [NT-1:0][SW-1:0]  bound_o,
    output logic [NT-1:0][AW-1:0]  redir_o
);
    localparam logic [AW-1:0] STEP = AW'(fs_pkg::INSN_BYTES);

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic          l_take;
        logic [SW-1:0] l_bound;
        logic [AW-1:0] l_redir;

        // Oldest boundary wins; strict compare keeps the lower port on ties.
        always_comb begin
            l_take  = 1'b0;
            l_bound = '0;
            l_redir = '0;
            for (int i = 0; i < SQP; i++) begin
                if (sq_valid[i] && (sq_tid[i] == TW'(t)) &&
                    (!l_take || (sq_bound[i] < l_bound))) begin
                    l_take  = 1'b1;
                    l_bound = sq_bound[i];
                    l_redir = sq_ctrl[i] ? sq_target[i] : sq_pc[i] + STEP;
                end
            end
        end

        assign take_o[t]  = l_take;
        assign bound_o[t] = l_bound;
        assign redir_o[t] = l_redir;
    end
endmodule

// File: rtl/fs_thread.sv
module fs_thread #(
    parameter int AW = 32,
    parameter int SW = 16,
    parameter int CW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [AW-1:0]     act_pc_i,
    input  logic              deact_i,
    input  logic              sq_i,
    input  logic [SW-1:0]     sq_bound_i,
    input  logic [AW-1:0]     sq_redir_i,
    input  logic              br_i,
    input  fs_pkg::br_kind_e  br_kind_i,
    input  logic [AW-1:0]     br_pc_i,
    input  logic [AW-1:0]     br_tgt_i,
    input  logic              fetch_i,
    output logic              run_o,
    output logic [AW-1:0]     addr_o,
    output logic [SW-1:0]     seq_o
);
    import fs_pkg::*;

    localparam logic [AW-1:0] STEP  = AW'(INSN_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * INSN_BYTES);

    th_state_e     state_q, state_d;
    logic [AW-1:0] cur_q, nxt_q, nn_q, tgt_q;
    logic [CW-1:0] pend_q;
    logic          rdy_q;
    logic [SW-1:0] seq_q;

    logic          use_tgt;
    logic [AW-1:0] b_nxt, b_nn;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TH_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_OFF:      if (act_i || sq_i) state_d = TH_RUN;
            TH_RUN:      if (br_i && (br_kind_i == BR_RETURN_NT)) state_d = TH_WAIT_RET;
            TH_WAIT_RET: if (act_i || sq_i) state_d = TH_RUN;
            default:     state_d = TH_OFF;
        endcase
        if (deact_i) state_d = TH_OFF;
    end

    // Window view after an eventual redirect load
    assign use_tgt = rdy_q && (pend_q == '0);
    assign addr_o  = use_tgt ? tgt_q : cur_q;
    assign b_nxt   = use_tgt ? tgt_q + STEP  : nxt_q;
    assign b_nn    = use_tgt ? tgt_q + STEP2 : nn_q;
    assign run_o   = (state_q == TH_RUN);
    assign seq_o   = seq_q;

    // Window, delay-slot and sequence bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            nxt_q  <= '0;
            nn_q   <= '0;
            tgt_q  <= '0;
            pend_q <= '0;
            rdy_q  <= 1'b0;
            seq_q  <= '0;
        end else if (deact_i) begin
            pend_q <= '0;
            rdy_q  <= 1'b0;
        end else if (act_i) begin
            cur_q  <= act_pc_i;
            nxt_q  <= act_pc_i + STEP;
            nn_q   <= act_pc_i + STEP2;
            pend_q <= '0;
            rdy_q  <= 1'b0;
        end else if (sq_i) begin
            rdy_q <= 1'b0;
            if (seq_q == sq_bound_i) begin
                pend_q <= CW'(1);
                tgt_q  <= sq_redir_i;
            end else begin
                pend_q <= '0;
                cur_q  <= sq_redir_i;
                nxt_q  <= sq_redir_i + STEP;
                nn_q   <= sq_redir_i + STEP2;
            end
        end else if (br_i) begin
            unique case (br_kind_i)
                BR_TAKEN: begin
                    pend_q <= pend_q + CW'(1);
                    rdy_q  <= 1'b0;
                    tgt_q  <= br_tgt_i;
                end
                BR_NOT_TAKEN: begin
                    pend_q <= pend_q + CW'(1);
                    rdy_q  <= 1'b0;
                    tgt_q  <= br_pc_i + STEP2;
                end
                BR_ANNUL_NT, BR_RETURN_NT: begin
                end
            endcase
        end else if (fetch_i) begin
            cur_q <= b_nxt;
            nxt_q <= b_nn;
            nn_q  <= b_nn + STEP;
            seq_q <= seq_q + SW'(1);
            if (pend_q != '0) begin
                pend_q <= pend_q - CW'(1);
                rdy_q  <= (pend_q == CW'(1));
            end else if (use_tgt) begin
                rdy_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer #(
    parameter int NT  = 2,
    parameter int AW  = 32,
    parameter int SW  = 16,
    parameter int CW  = 3,
    parameter int STW = 3,
    parameter int SQP = 2,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    act_valid,
    input  logic [TW-1:0]           act_tid,
    input  logic [AW-1:0]           act_pc,
    input  logic                    deact_valid,
    input  logic [TW-1:0]           deact_tid,
    input  logic                    fetch_req,
    input  logic [TW-1:0]           fetch_tid,
    output logic                    rsp_valid,
    output logic                    rsp_stall,
    output logic [AW-1:0]           rsp_addr,
    output logic [SW-1:0]           rsp_seq,
    input  logic                    br_valid,
    input  logic [TW-1:0]           br_tid,
    input  logic [1:0]              br_kind,
    input  logic [SW-1:0]           br_seq,
    input  logic [AW-1:0]           br_pc,
    input  logic [AW-1:0]           br_target,
    input  logic [STW-1:0]          br_stage,
    output logic                    kill_valid,
    output logic [TW-1:0]           kill_tid,
    output logic [SW-1:0]           kill_seq,
    output logic                    hold_valid,
    output logic [TW-1:0]           hold_tid,
    output logic [STW-1:0]          hold_stage,
    input  logic [SQP-1:0]          sq_valid,
    input  logic [SQP-1:0][TW-1:0]  sq_tid,
    input  logic [SQP-1:0][SW-1:0]  sq_bound,
    input  logic [SQP-1:0]          sq_ctrl,
    input  logic [SQP-1:0][AW-1:0]  sq_pc,
    input  logic [SQP-1:0][AW-1:0]  sq_target,
    output logic [NT-1:0]           release_mask,
    output logic [NT-1:0][STW-1:0]  release_stage
);
    import fs_pkg::*;

    br_kind_e              br_kind_c;
    logic [NT-1:0]         sq_take;
    logic [NT-1:0][SW-1:0] sq_bnd;
    logic [NT-1:0][AW-1:0] sq_rdr;
    logic [NT-1:0]         busy, br_en, fetch_en, thr_run;
    logic [AW-1:0]         thr_addr [NT];
    logic [SW-1:0]         thr_seq  [NT];
    logic [NT-1:0][STW-1:0] blk_stage_q;
    logic                  br_ok, fetch_ok;

    assign br_kind_c = br_kind_e'(br_kind);

    fs_squash_pick #(
        .NT(NT), .SQP(SQP), .TW(TW), .SW(SW), .AW(AW)
    ) u_pick (
        .sq_valid  (sq_valid),
        .sq_tid    (sq_tid),
        .sq_bound  (sq_bound),
        .sq_ctrl   (sq_ctrl),
        .sq_pc     (sq_pc),
        .sq_target (sq_target),
        .take_o    (sq_take),
        .bound_o   (sq_bnd),
        .redir_o   (sq_rdr)
    );

    for (genvar t = 0; t < NT; t++) begin : g_th
        logic act_t, deact_t;
        assign act_t       = act_valid   && (act_tid   == TW'(t));
        assign deact_t     = deact_valid && (deact_tid == TW'(t));
        assign busy[t]     = act_t || deact_t || sq_take[t];
        assign br_en[t]    = br_valid && (br_tid == TW'(t)) && !busy[t];
        assign fetch_en[t] = fetch_req && (fetch_tid == TW'(t)) && thr_run[t]
                             && !busy[t] && !br_en[t];

        fs_thread #(.AW(AW), .SW(SW), .CW(CW)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act_t),
            .act_pc_i   (act_pc),
            .deact_i    (deact_t),
            .sq_i       (sq_take[t]),
            .sq_bound_i (sq_bnd[t]),
            .sq_redir_i (sq_rdr[t]),
            .br_i       (br_en[t]),
            .br_kind_i  (br_kind_c),
            .br_pc_i    (br_pc),
            .br_tgt_i   (br_target),
            .fetch_i    (fetch_en[t]),
            .run_o      (thr_run[t]),
            .addr_o     (thr_addr[t]),
            .seq_o      (thr_seq[t])
        );
    end

    assign br_ok         = |br_en;
    assign fetch_ok      = |fetch_en;
    assign release_stage = blk_stage_q;

    // Response, kill, hold and release outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_stall    <= 1'b0;
            rsp_addr     <= '0;
            rsp_seq      <= '0;
            kill_valid   <= 1'b0;
            kill_tid     <= '0;
            kill_seq     <= '0;
            hold_valid   <= 1'b0;
            hold_tid     <= '0;
            hold_stage   <= '0;
            release_mask <= '0;
            blk_stage_q  <= '0;
        end else begin
            rsp_valid <= fetch_req && fetch_ok;
            rsp_stall <= fetch_req && !fetch_ok;
            if (fetch_req && fetch_ok) begin
                rsp_addr <= thr_addr[fetch_tid];
                rsp_seq  <= thr_seq[fetch_tid];
            end
            kill_valid <= br_ok && ((br_kind_c == BR_TAKEN) || (br_kind_c == BR_ANNUL_NT));
            kill_tid   <= br_tid;
            kill_seq   <= (br_kind_c == BR_TAKEN) ? br_seq + SW'(1) : br_seq;
            hold_valid <= br_ok && (br_kind_c == BR_RETURN_NT);
            hold_tid   <= br_tid;
            hold_stage <= br_stage;
            release_mask <= sq_take & ~thr_run;
            if (deact_valid)
                blk_stage_q[deact_tid] <= '0;
            else if (br_ok && (br_kind_c == BR_RETURN_NT))
                blk_stage_q[br_tid] <= br_stage;
        end
    end
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int NT  = 2,
    parameter int SW  = 16,
    parameter int STW = 3,
    parameter int SQP = 2,
    parameter int TW  = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_req,
    input logic [TW-1:0]  fetch_tid,
    input logic [NT-1:0]  thr_run,
    input logic           rsp_valid,
    input logic           rsp_stall,
    input logic           br_ok,
    input logic [1:0]     br_kind,
    input logic [SW-1:0]  br_seq,
    input logic [STW-1:0] br_stage,
    input logic           kill_valid,
    input logic [SW-1:0]  kill_seq,
    input logic           hold_valid,
    input logic [STW-1:0] hold_stage,
    input logic [SQP-1:0] sq_valid,
    input logic [NT-1:0]  release_mask
);
    assert_rsp_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_stall}));

    assert_stall_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !thr_run[fetch_tid] |=> rsp_stall && !rsp_valid);

    assert_kill_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok && (br_kind == 2'd0) |=> kill_valid && (kill_seq == $past(br_seq) + SW'(1)));

    assert_kill_annul_R5: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok && (br_kind == 2'd2) |=> kill_valid && (kill_seq == $past(br_seq)));

    assert_no_kill_nt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok && (br_kind == 2'd1) |=> !kill_valid);

    assert_hold_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_ok && (br_kind == 2'd3) |=> hold_valid && (hold_stage == $past(br_stage)));

    assert_release_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (release_mask != '0) |-> $past(sq_valid != '0));
endmodule

bind fetch_sequencer fs_checker #(
    .NT(NT), .SW(SW), .STW(STW), .SQP(SQP), .TW(TW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .fetch_tid    (fetch_tid),
    .thr_run      (thr_run),
    .rsp_valid    (rsp_valid),
    .rsp_stall    (rsp_stall),
    .br_ok        (br_ok),
    .br_kind      (br_kind),
    .br_seq       (br_seq),
    .br_stage     (br_stage),
    .kill_valid   (kill_valid),
    .kill_seq     (kill_seq),
    .hold_valid   (hold_valid),
    .hold_stage   (hold_stage),
    .sq_valid     (sq_valid),
    .release_mask (release_mask)
);

// File: tb/sim_fetch_sequencer.sv
`timescale 1ns/1ps
module sim_fetch_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        act_valid = 0, deact_valid = 0, fetch_req = 0, br_valid = 0;
    logic [0:0]  act_tid = 0, deact_tid = 0, fetch_tid = 0, br_tid = 0;
    logic [31:0] act_pc = 0, br_pc = 0, br_target = 0;
    logic [1:0]  br_kind = 0;
    logic [15:0] br_seq = 0;
    logic [2:0]  br_stage = 0;
    logic        rsp_valid, rsp_stall, kill_valid, hold_valid;
    logic [31:0] rsp_addr;
    logic [15:0] rsp_seq, kill_seq;
    logic [0:0]  kill_tid, hold_tid;
    logic [2:0]  hold_stage;
    logic [1:0]        sq_valid = 0, sq_ctrl = 0;
    logic [1:0][0:0]   sq_tid = 0;
    logic [1:0][15:0]  sq_bound = 0;
    logic [1:0][31:0]  sq_pc = 0, sq_target = 0;
    logic [1:0]        release_mask;
    logic [1:0][2:0]   release_stage;

    fetch_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .act_valid(act_valid), .act_tid(act_tid), .act_pc(act_pc),
        .deact_valid(deact_valid), .deact_tid(deact_tid),
        .fetch_req(fetch_req), .fetch_tid(fetch_tid),
        .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_addr(rsp_addr), .rsp_seq(rsp_seq),
        .br_valid(br_valid), .br_tid(br_tid), .br_kind(br_kind), .br_seq(br_seq),
        .br_pc(br_pc), .br_target(br_target), .br_stage(br_stage),
        .kill_valid(kill_valid), .kill_tid(kill_tid), .kill_seq(kill_seq),
        .hold_valid(hold_valid), .hold_tid(hold_tid), .hold_stage(hold_stage),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_bound(sq_bound), .sq_ctrl(sq_ctrl),
        .sq_pc(sq_pc), .sq_target(sq_target),
        .release_mask(release_mask), .release_stage(release_stage)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // {tid, expected address, expected sequence}
    localparam logic [48:0] VEC [0:7] = '{
        {1'b0, 32'h0000_1000, 16'd0},
        {1'b1, 32'h0000_8000, 16'd0},
        {1'b0, 32'h0000_1004, 16'd1},
        {1'b0, 32'h0000_1008, 16'd2},
        {1'b1, 32'h0000_8004, 16'd1},
        {1'b1, 32'h0000_8008, 16'd2},
        {1'b0, 32'h0000_100C, 16'd3},
        {1'b1, 32'h0000_800C, 16'd3}
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_fetch(input logic tid, input logic [31:0] ea, input logic [15:0] es, input string req);
        fetch_req = 1; fetch_tid = tid;
        cyc();
        fetch_req = 0;
        chk(rsp_valid && !rsp_stall, req, {30'd0, rsp_valid, rsp_stall}, 32'h2);
        chk(rsp_addr == ea, req, rsp_addr, ea);
        chk(rsp_seq == es, req, {16'd0, rsp_seq}, {16'd0, es});
    endtask

    task automatic do_stall(input logic tid, input string req);
        fetch_req = 1; fetch_tid = tid;
        cyc();
        fetch_req = 0;
        chk(rsp_stall && !rsp_valid, req, {30'd0, rsp_valid, rsp_stall}, 32'h1);
    endtask

    task automatic do_br(input logic tid, input logic [1:0] k, input logic [15:0] s,
                         input logic [31:0] pc, input logic [31:0] tg, input logic [2:0] st);
        br_valid = 1; br_tid = tid; br_kind = k; br_seq = s;
        br_pc = pc; br_target = tg; br_stage = st;
        cyc();
        br_valid = 0;
    endtask

    task automatic set_sq(input int p, input logic tid, input logic [15:0] b,
                          input logic c, input logic [31:0] pc, input logic [31:0] tg);
        sq_valid[p] = 1; sq_tid[p] = tid; sq_bound[p] = b;
        sq_ctrl[p] = c; sq_pc[p] = pc; sq_target[p] = tg;
    endtask

    task automatic activate(input logic tid, input logic [31:0] pc);
        act_valid = 1; act_tid = tid; act_pc = pc;
        cyc();
        act_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(!rsp_valid && !kill_valid && !hold_valid && release_mask == 0, "R1 idle outputs",
            {28'd0, rsp_valid, kill_valid, hold_valid, |release_mask}, 32'h0);
        rst_n = 1;
        cyc();
        do_stall(1'b0, "R1 thread off after reset");

        // R2 table walk on two threads
        activate(1'b0, 32'h1000);
        activate(1'b1, 32'h8000);
        for (int i = 0; i < 8; i++)
            do_fetch(VEC[i][48], VEC[i][47:16], VEC[i][15:0], "R2 window advance");

        // R4 taken branch with delay slot
        do_fetch(1'b0, 32'h1010, 16'd4, "R4 branch fetch");
        do_br(1'b0, 2'd0, 16'd4, 32'h1010, 32'h2000, 3'd1);
        chk(kill_valid && kill_tid == 0 && kill_seq == 16'd5, "R4 kill boundary", {16'd0, kill_seq}, 32'd5);
        do_fetch(1'b0, 32'h1014, 16'd5, "R4 delay slot");
        do_fetch(1'b0, 32'h2000, 16'd6, "R4 target");
        do_fetch(1'b0, 32'h2004, 16'd7, "R4 after target");

        // R5 annulling not-taken
        do_fetch(1'b0, 32'h2008, 16'd8, "R5 branch fetch");
        do_br(1'b0, 2'd2, 16'd8, 32'h2008, 32'h0, 3'd1);
        chk(kill_valid && kill_seq == 16'd8, "R5 kill boundary", {16'd0, kill_seq}, 32'd8);
        do_fetch(1'b0, 32'h200C, 16'd9, "R5 sequential");

        // R6 plain not-taken
        do_fetch(1'b0, 32'h2010, 16'd10, "R6 branch fetch");
        do_br(1'b0, 2'd1, 16'd10, 32'h2010, 32'h9999, 3'd1);
        chk(!kill_valid, "R6 no kill", {31'd0, kill_valid}, 32'd0);
        do_fetch(1'b0, 32'h2014, 16'd11, "R6 delay slot");
        do_fetch(1'b0, 32'h2018, 16'd12, "R6 fall-through");
        do_fetch(1'b0, 32'h201C, 16'd13, "R6 continue");

        // R7 return hold
        do_br(1'b0, 2'd3, 16'd13, 32'h201C, 32'h0, 3'd3);
        chk(hold_valid && hold_tid == 0 && hold_stage == 3'd3, "R7 hold", {29'd0, hold_stage}, 32'd3);
        do_stall(1'b0, "R7 stall while waiting");

        // R10 squash releases held thread, R8 control redirect
        set_sq(0, 1'b0, 16'd13, 1'b1, 32'h0, 32'h3000);
        cyc();
        sq_valid = 0;
        chk(release_mask == 2'b01, "R10 release bit", {30'd0, release_mask}, 32'h1);
        chk(release_stage[0] == 3'd3, "R10 release stage", {29'd0, release_stage[0]}, 32'd3);
        do_fetch(1'b0, 32'h3000, 16'd14, "R8 control redirect");
        do_fetch(1'b0, 32'h3004, 16'd15, "R8 after redirect");

        // R8 non-control redirect
        set_sq(0, 1'b0, 16'd10, 1'b0, 32'h3100, 32'h0);
        cyc();
        sq_valid = 0;
        chk(release_mask == 2'b00, "R10 no release while running", {30'd0, release_mask}, 32'h0);
        do_fetch(1'b0, 32'h3104, 16'd16, "R8 pc plus four");

        // R9 delay slot not yet fetched
        set_sq(0, 1'b0, 16'd17, 1'b1, 32'h0, 32'h4000);
        cyc();
        sq_valid = 0;
        do_fetch(1'b0, 32'h3108, 16'd17, "R9 delay slot kept");
        do_fetch(1'b0, 32'h4000, 16'd18, "R9 redirect after slot");

        // R11 contested squashes
        set_sq(0, 1'b0, 16'd30, 1'b1, 32'h0, 32'h5000);
        set_sq(1, 1'b0, 16'd20, 1'b1, 32'h0, 32'h6000);
        cyc();
        sq_valid = 0;
        do_fetch(1'b0, 32'h6000, 16'd19, "R11 older on port 1");
        set_sq(0, 1'b0, 16'd25, 1'b1, 32'h0, 32'h7000);
        set_sq(1, 1'b0, 16'd25, 1'b1, 32'h0, 32'h7100);
        cyc();
        sq_valid = 0;
        do_fetch(1'b0, 32'h7000, 16'd20, "R11 tie to port 0");
        set_sq(0, 1'b0, 16'd5, 1'b1, 32'h0, 32'h7200);
        set_sq(1, 1'b0, 16'd9, 1'b1, 32'h0, 32'h7300);
        cyc();
        sq_valid = 0;
        do_fetch(1'b0, 32'h7200, 16'd21, "R11 older on port 0");

        // R13 collisions
        set_sq(0, 1'b0, 16'd1, 1'b1, 32'h0, 32'h7400);
        do_stall(1'b0, "R13 fetch loses to squash");
        sq_valid = 0;
        do_fetch(1'b0, 32'h7400, 16'd22, "R13 sequence not consumed");
        set_sq(0, 1'b0, 16'd2, 1'b1, 32'h0, 32'h7500);
        do_fetch(1'b1, 32'h8010, 16'd4, "R13 other thread unaffected");
        sq_valid = 0;

        // R12 deactivate drops pending redirect
        do_br(1'b1, 2'd0, 16'd4, 32'h8010, 32'h9000, 3'd2);
        chk(kill_valid && kill_tid == 1 && kill_seq == 16'd5, "R12 kill on thread 1", {16'd0, kill_seq}, 32'd5);
        deact_valid = 1; deact_tid = 1'b1;
        cyc();
        deact_valid = 0;
        do_stall(1'b1, "R12 stall after deactivate");
        activate(1'b1, 32'hA000);
        do_fetch(1'b1, 32'hA000, 16'd5, "R12 restart");
        do_fetch(1'b1, 32'hA004, 16'd6, "R12 no leftover redirect");
        do_fetch(1'b0, 32'h7500, 16'd23, "R13 squash applied on thread 0");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule